// File: doc/BRIEF.md
# Slot Power and Reset Sequencer

This block sequences the slot power enable and the active-low slot reset for one hot-plug downstream port. Software asks for power with a single control bit (zero means power on). On power-up the block raises the power enable first and holds the slot in reset. Reset is released only after a programmable on-delay. In power-good mode, reset also waits for the power-good input to have stayed high for that delay. On power-down the block asserts reset at once and drops power enable after a second programmable off-delay.

Both delays count a one-microsecond tick. The block also guarantees in hardware a minimum reset pulse width, counted in ticks from each reset assertion, whatever software writes. The two slot pins start out undriven, because after a fundamental reset they are plain general-purpose inputs. The block therefore also provides a registered output-enable that follows a configuration input. The analog power switch itself lies outside this block.

Top module: `slot_pwr_seq`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `slot_pwr_en`=0, `slot_rst_n`=0 and `pin_oe`=0.
- R2: `pin_oe` equals the value `drive_en` had at the previous clock edge.
- R3: When `sw_pwr_off` goes to 0 while the slot is off, `slot_pwr_en` becomes 1 after the next clock edge, and `slot_rst_n` stays 0.
- R4: With `rst_mode`=0 (power-enable mode), `slot_rst_n` rises one cycle after the (`on_dly`+1)-th tick that follows power enable, unless R5 holds it longer. `pwr_good` has no effect in this mode.
- R5: Every assertion of `slot_rst_n` lasts at least `MIN_RST_TICKS` ticks, counted from the assertion. A release that is due earlier waits for the last of these ticks.
- R6: When `sw_pwr_off` goes to 1 while reset is released, `slot_rst_n` falls after the next edge. `slot_pwr_en` stays 1 until one cycle after the (`off_dly`+1)-th tick that follows.
- R7: `slot_rst_n` is never 1 while `slot_pwr_en` is 0.
- R8: With `rst_mode`=1 (power-good mode), the release needs `pwr_good` to have been high at each of `on_dly`+1 ticks in a row. A low `pwr_good` restarts the count.
- R9: Turning power back on during the off-delay keeps `slot_pwr_en` at 1 and reset asserted, and restarts the on-delay. The release waits for both that delay and R5.
- R10: Turning power off during the on-delay leaves reset asserted, and `slot_pwr_en` falls one cycle after the (`off_dly`+1)-th tick that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| drive_en | input | 1 | Selects the output function of the two slot pins |
| sw_pwr_off | input | 1 | Software power control: 0 = power on, 1 = power off |
| rst_mode | input | 1 | 0 = power-enable mode, 1 = power-good mode |
| on_dly | input | DLY_W | Ticks from power enable (or power good) to reset release, minus one |
| off_dly | input | DLY_W | Ticks from reset assertion to power removal, minus one |
| pwr_good | input | 1 | Slot supply good indication |
| slot_pwr_en | output | 1 | Slot power enable, active high |
| slot_rst_n | output | 1 | Slot reset, active low |
| pin_oe | output | 1 | Output enable for the two slot pins |

## Verification
The assertions assume that `us_tick` is a single-cycle pulse with at least one idle cycle between pulses. They also assume that `rst_mode`, `on_dly` and `off_dly` change only while the slot is off or while their value is not in use. The stimulus meets both: the tick comes every fourth cycle, and the mode and delay inputs are written only in the off state or before the control bit that starts the phase using them. `pwr_good` is driven only on falling clock edges, so it stays stable across each sampling edge.

// File: rtl/slot_pwr_seq_pkg.sv
// Shared types for the slot power and reset sequencer.
package slot_pwr_seq_pkg;

    // Reset release policy selected by the mode input.
    typedef enum logic {
        MODE_PWR_EN   = 1'b0,
        MODE_PWR_GOOD = 1'b1
    } rel_mode_e;

    // Slot sequencing phases.
    typedef enum logic [1:0] {
        PH_OFF   = 2'd0,   // power off, reset asserted
        PH_RAMP  = 2'd1,   // power on, reset asserted, waiting to release
        PH_ON    = 2'd2,   // power on, reset released
        PH_DRAIN = 2'd3    // reset asserted, waiting to remove power
    } phase_e;

endpackage

// File: rtl/slot_tick_timer.sv
// Tick-counted one-shot delay.
// While run is low the counter reloads from dly and expired is cleared.
// While run is high, each tick counts down; the tick seen at count zero sets
// expired, so a dly of N expires on the (N+1)-th tick. expired stays set until
// run drops. Assumes tick is a single-cycle pulse.
module slot_tick_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         tick,
    input  logic [W-1:0] dly,
    output logic         expired
);
    logic [W-1:0] cnt;

    // Reload on idle, count ticks while running, latch expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt     <= dly;
            expired <= 1'b0;
        end else if (tick && !expired) begin
            if (cnt == '0) expired <= 1'b1;
            else           cnt     <= cnt - 1'b1;
        end
    end

    a_r4_expire_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(expired) |-> $past(tick && run));

endmodule

// File: rtl/slot_min_hold.sv
// Minimum reset-width guard.
// Counts ticks while hold is high and saturates at MIN_TICKS; met goes high
// once the count is reached. Dropping hold clears the count, so every new
// assertion restarts the measurement. Assumes MIN_TICKS >= 1.
module slot_min_hold #(
    parameter int MIN_TICKS = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic tick,
    output logic met
);
    localparam int CW = $clog2(MIN_TICKS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(MIN_TICKS);

    logic [CW-1:0] cnt;

    // Saturating tick count of the current reset assertion.
    always_ff @(posedge clk) begin
        if (!rst_n || !hold)            cnt <= '0;
        else if (tick && cnt != LIMIT)  cnt <= cnt + 1'b1;
    end

    assign met = (cnt == LIMIT);

    a_r5_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LIMIT);

    a_r5_restart_on_release: assert property (@(posedge clk) disable iff (!rst_n)
        !hold |=> cnt == '0);

endmodule

// File: rtl/slot_seq_fsm.sv
// Phase sequencer for the slot power and reset outputs.
// Moves OFF -> RAMP on a power request, RAMP -> ON once the on-delay has
// expired and the minimum width is met (and power good is high in
// power-good mode), and ON/RAMP -> DRAIN -> OFF on a power-off request.
// A power request during DRAIN returns to RAMP with power kept on.
// Assumes the mode input changes only while the slot is off.
module slot_seq_fsm
    import slot_pwr_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sw_off,
    input  rel_mode_e mode,
    input  logic      pwr_good,
    input  logic      on_exp,
    input  logic      off_exp,
    input  logic      min_met,
    output logic      on_run,
    output logic      off_run,
    output logic      pwr_en,
    output logic      rst_rel
);
    phase_e phase, phase_nx;
    logic   pg_ok;

    assign pg_ok = (mode == MODE_PWR_EN) || pwr_good;

    // Next-phase selection.
    always_comb begin
        phase_nx = phase;
        unique case (phase)
            PH_OFF:   if (!sw_off) phase_nx = PH_RAMP;
            PH_RAMP:  if (sw_off)  phase_nx = PH_DRAIN;
                      else if (on_exp && min_met && pg_ok) phase_nx = PH_ON;
            PH_ON:    if (sw_off)  phase_nx = PH_DRAIN;
            PH_DRAIN: if (!sw_off) phase_nx = PH_RAMP;
                      else if (off_exp) phase_nx = PH_OFF;
            default:  phase_nx = PH_OFF;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_OFF;
        else        phase <= phase_nx;
    end

    // Output and timer-enable decode from the registered phase.
    assign pwr_en  = (phase != PH_OFF);
    assign rst_rel = (phase == PH_ON);
    assign on_run  = (phase == PH_RAMP) && pg_ok;
    assign off_run = (phase == PH_DRAIN);

    a_r8_release_needs_pg: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rst_rel) && mode == MODE_PWR_GOOD) |-> $past(pwr_good));

    a_r9_no_drop_on_reentry: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DRAIN && !sw_off) |=> (phase == PH_RAMP && pwr_en));

endmodule

// File: rtl/slot_pwr_seq.sv
// Slot power and reset sequencer, top level.
// Ties the phase sequencer to two tick timers (on-delay and off-delay) and a
// minimum reset-width guard, and registers the pin output-enable.
// Assumes us_tick is a single-cycle pulse and the delay inputs stay stable
// while the phase that uses them is in progress.
module slot_pwr_seq
    import slot_pwr_seq_pkg::*;
#(
    parameter int DLY_W         = 8,
    parameter int MIN_RST_TICKS = 200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             us_tick,
    input  logic             drive_en,
    input  logic             sw_pwr_off,
    input  logic             rst_mode,
    input  logic [DLY_W-1:0] on_dly,
    input  logic [DLY_W-1:0] off_dly,
    input  logic             pwr_good,
    output logic             slot_pwr_en,
    output logic             slot_rst_n,
    output logic             pin_oe
);
    logic      on_run, off_run, on_exp, off_exp, min_met, rst_rel;
    rel_mode_e mode;

    assign mode = rel_mode_e'(rst_mode);

    slot_seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_off   (sw_pwr_off),
        .mode     (mode),
        .pwr_good (pwr_good),
        .on_exp   (on_exp),
        .off_exp  (off_exp),
        .min_met  (min_met),
        .on_run   (on_run),
        .off_run  (off_run),
        .pwr_en   (slot_pwr_en),
        .rst_rel  (rst_rel)
    );

    slot_tick_timer #(.W(DLY_W)) u_on_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (on_run),
        .tick    (us_tick),
        .dly     (on_dly),
        .expired (on_exp)
    );

    slot_tick_timer #(.W(DLY_W)) u_off_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (off_run),
        .tick    (us_tick),
        .dly     (off_dly),
        .expired (off_exp)
    );

    slot_min_hold #(.MIN_TICKS(MIN_RST_TICKS)) u_min (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (!rst_rel),
        .tick  (us_tick),
        .met   (min_met)
    );

    assign slot_rst_n = rst_rel;

    // Output-enable for the slot pins, undriven out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_oe <= 1'b0;
        else        pin_oe <= drive_en;
    end

    a_r7_rst_while_off: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_pwr_en |-> !slot_rst_n);

    a_r3_power_before_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slot_rst_n) |-> $past(slot_pwr_en));

    a_r5_release_after_min: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slot_rst_n) |-> $past(min_met));

    a_r6_reset_before_power_off: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(slot_pwr_en) |-> ($past(off_exp) && !$past(slot_rst_n)));

endmodule

// File: tb/slot_pwr_seq_tb.sv
// Scoreboard bench: the driver queues expected output changes with the tick
// number at which each must appear, and the monitor compares them.
module slot_pwr_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DLY_W      = 8;
    localparam int MIN_T      = 200;

    typedef struct {
        logic  pwr;
        logic  rst;
        int    tick;   // -1: timing not checked
        string tag;
    } exp_t;

    logic clk = 1'b0, rst_n = 1'b0, us_tick = 1'b0;
    logic drive_en = 1'b0, sw_pwr_off = 1'b1, rst_mode = 1'b0, pwr_good = 1'b0;
    logic [DLY_W-1:0] on_dly = '0, off_dly = '0;
    logic slot_pwr_en, slot_rst_n, pin_oe;

    int   total = 0, bad = 0, tick_no = 0, div = 0, assert_tick = 0;
    logic r7_bad = 1'b0, done = 1'b0;
    logic [1:0] prev = 2'b00;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    slot_pwr_seq #(.DLY_W(DLY_W), .MIN_RST_TICKS(MIN_T)) u_dut (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .drive_en(drive_en),
        .sw_pwr_off(sw_pwr_off), .rst_mode(rst_mode), .on_dly(on_dly),
        .off_dly(off_dly), .pwr_good(pwr_good), .slot_pwr_en(slot_pwr_en),
        .slot_rst_n(slot_rst_n), .pin_oe(pin_oe)
    );

    // Tick every fourth cycle, changed on falling edges.
    always @(negedge clk) begin
        if (!rst_n) begin div <= 0; us_tick <= 1'b0; end
        else begin div <= (div == 3) ? 0 : div + 1; us_tick <= (div == 3); end
    end

    // Ticks consumed by the design since reset.
    always @(posedge clk) begin
        if (!rst_n)       tick_no <= 0;
        else if (us_tick) tick_no <= tick_no + 1;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: each output change pops one expected item.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!slot_pwr_en && slot_rst_n) r7_bad <= 1'b1;
            if ({slot_pwr_en, slot_rst_n} != prev) begin
                if (q.size() == 0) begin
                    check(0, "unexpected change", {30'd0, slot_pwr_en, slot_rst_n}, {30'd0, prev});
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check({slot_pwr_en, slot_rst_n} == {e.pwr, e.rst}, {e.tag, " value"},
                          {slot_pwr_en, slot_rst_n}, {e.pwr, e.rst});
                    if (e.tick >= 0) check(tick_no == e.tick, {e.tag, " tick"}, tick_no, e.tick);
                end
                prev <= {slot_pwr_en, slot_rst_n};
            end
        end else begin
            prev <= 2'b00;
        end
    end

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic push(input logic p, input logic r, input int t, input string tag);
        exp_t e;
        e.pwr = p; e.rst = r; e.tick = t; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic wait_ticks(input int n);
        int target;
        target = tick_no + n;
        while (tick_no < target) @(negedge clk);
    endtask

    task automatic wait_empty(input string tag);
        int guard;
        guard = 0;
        while (q.size() != 0 && guard < 20000) begin @(negedge clk); guard++; end
        check(q.size() == 0, {tag, " expected change seen"}, q.size(), 0);
        q.delete();
    endtask

    // Power on from OFF or re-enable during drain; queue the release.
    task automatic power_on(input int on_v, input bit from_off, input string tag);
        int entry;
        on_dly = DLY_W'(on_v);
        if (from_off) push(1'b1, 1'b0, -1, "R3");
        sw_pwr_off = 1'b0;
        @(negedge clk);
        entry = tick_no;
        if (from_off) check(slot_pwr_en == 1'b1 && slot_rst_n == 1'b0, "R3 power first",
                            {slot_pwr_en, slot_rst_n}, 2);
        push(1'b1, 1'b1, imax(assert_tick + MIN_T, entry + on_v + 1), tag);
    endtask

    // Power off from ON; reset first, power after the off-delay.
    task automatic power_off(input int off_v);
        off_dly = DLY_W'(off_v);
        push(1'b1, 1'b0, -1, "R6 reset assert");
        sw_pwr_off = 1'b1;
        @(negedge clk);
        assert_tick = tick_no;
        check(slot_pwr_en == 1'b1 && slot_rst_n == 1'b0, "R6 reset first",
              {slot_pwr_en, slot_rst_n}, 2);
        push(1'b0, 1'b0, assert_tick + off_v + 1, "R6 power off");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(slot_pwr_en == 0 && slot_rst_n == 0 && pin_oe == 0, "R1 during reset",
              {pin_oe, slot_pwr_en, slot_rst_n}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(slot_pwr_en == 0 && slot_rst_n == 0 && pin_oe == 0, "R1 after reset",
              {pin_oe, slot_pwr_en, slot_rst_n}, 0);

        drive_en = 1'b1;
        @(negedge clk);
        check(pin_oe == 1'b1, "R2 oe follows", pin_oe, 1);

        // R5: first power-up, minimum width dominates, pwr_good low (R4 ignore).
        power_on(5, 1'b1, "R5 min width first release");
        wait_empty("R5");
        power_off(3);
        wait_empty("R6");

        // R4: long wait in OFF, on-delay dominates.
        wait_ticks(MIN_T + 10);
        power_on(20, 1'b1, "R4 on-delay release");
        wait_empty("R4");

        // R9: re-enable during drain, minimum width dominates.
        off_dly = DLY_W'(50);
        push(1'b1, 1'b0, -1, "R9 reset assert");
        sw_pwr_off = 1'b1;
        @(negedge clk);
        assert_tick = tick_no;
        wait_ticks(5);
        power_on(10, 1'b0, "R9 min dominates");
        wait_empty("R9a");

        // R9: re-enable late in drain, on-delay dominates.
        off_dly = DLY_W'(255);
        push(1'b1, 1'b0, -1, "R9 reset assert");
        sw_pwr_off = 1'b1;
        @(negedge clk);
        assert_tick = tick_no;
        wait_ticks(190);
        check(slot_pwr_en == 1'b1, "R9 power held in drain", slot_pwr_en, 1);
        power_on(30, 1'b0, "R9 on-delay dominates");
        wait_empty("R9b");

        // R10: power off during the on-delay.
        power_off(2);
        wait_empty("R6b");
        wait_ticks(5);
        on_dly = DLY_W'(100);
        push(1'b1, 1'b0, -1, "R3");
        sw_pwr_off = 1'b0;
        @(negedge clk);
        wait_ticks(10);
        off_dly = DLY_W'(7);
        sw_pwr_off = 1'b1;
        @(negedge clk);
        push(1'b0, 1'b0, tick_no + 8, "R10 power off from ramp");
        wait_empty("R10");

        // R8: power-good mode, glitch restarts the count.
        rst_mode = 1'b1;
        wait_ticks(MIN_T + 5);
        on_dly = DLY_W'(10);
        push(1'b1, 1'b0, -1, "R3");
        sw_pwr_off = 1'b0;
        @(negedge clk);
        wait_ticks(15);
        check(slot_rst_n == 1'b0, "R8 held without pwr_good", slot_rst_n, 0);
        pwr_good = 1'b1;
        wait_ticks(5);
        pwr_good = 1'b0;
        wait_ticks(3);
        check(slot_rst_n == 1'b0, "R8 held after glitch", slot_rst_n, 0);
        pwr_good = 1'b1;
        push(1'b1, 1'b1, imax(assert_tick + MIN_T, tick_no + 11), "R8 pg release");
        wait_empty("R8");

        check(r7_bad == 1'b0, "R7 reset while unpowered", r7_bad, 0);
        check(pin_oe == 1'b1, "R2 oe held", pin_oe, 1);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule